// File: doc/BRIEF.md
# Software register-entry sequence detector

This block sits in the access path of an asynchronous pseudo-static memory front end. It watches the stream of per-cycle accesses and looks for a fixed command pattern. The pattern is made of four accesses in a row, all aimed at the highest address. First come two reads. Then comes a write whose data is zero, which selects the refresh configuration register. The fourth access reaches that register in place of the array. A write on the fourth access programs the register, and a read on it returns the register's contents.

Any access that breaks the pattern drops the detector back to idle. The pattern can break through the wrong access type, a non-top address, or a nonzero select value. An extra read also breaks it. Every access other than the fourth one of a valid pattern passes straight through to the array. The register is 20 bits wide, but only its low 16 bits can be reached this way. The deep power-down enable bit can never be set through this path.

Top module: `sw_reg_entry`

## Requirements
- R1: While rst_ni is low, the sequence state returns to idle, cfg_o takes the value of parameter CFG_RESET (default 20'hA0003), and reg_acc_o is 0.
- R2: reg_acc_o is 1 only during an access (cyc_vld_i=1) to address 20'hFFFFF that directly follows three accesses. These must be, in order, a read of 20'hFFFFF, a read of 20'hFFFFF, and a write of 20'hFFFFF carrying data 16'h0000.
- R3: A write (cyc_we_i=1) on the register access loads cyc_wdata_i into cfg_o[15:0] on the next clock edge. Bit 4 is the exception.
- R4: A register write leaves cfg_o[19:16] unchanged.
- R5: Bit 4 of the register is the deep power-down enable. After a register write it is 0, whatever value the write data holds.
- R6: A read (cyc_we_i=0) on the register access drives {cfg_o[15:0]} on rdata_o in the same cycle.
- R7: When reg_acc_o is 0, rdata_o equals array_rdata_i.
- R8: An access to any address other than 20'hFFFFF, or of the wrong type for its position, aborts the pattern. The next entry then needs two fresh reads.
- R9: A third-position write whose data is not 16'h0000 aborts the pattern.
- R10: After the fourth access, the detector is idle. A third consecutive top read also aborts the pattern. Neither case allows a register access without a fresh read-read-write.
- R11: Cycles with cyc_vld_i=0 neither advance nor abort the pattern.
- R12: cfg_o changes only on the clock edge that ends a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_vld_i | input | 1 | An access is presented this cycle |
| cyc_we_i | input | 1 | 1 = write, 0 = read |
| cyc_addr_i | input | 20 | Access address |
| cyc_wdata_i | input | 16 | Write data |
| array_rdata_i | input | 16 | Read data from the array |
| rdata_o | output | 16 | Read data returned to the host |
| reg_acc_o | output | 1 | This access targets the configuration register |
| cfg_o | output | 20 | Configuration register contents |

## Verification
If the sequence state is wrong, the error shows up on the very access that should or should not have been the fourth. At that access reg_acc_o takes the wrong value, and rdata_o returns the wrong source when the access is a read. If the register update is wrong, cfg_o shows it one edge after the write. A lost DPD clear or a changed upper nibble is visible at that edge too. The random stream is biased heavily toward the top address and zero data, so long partial patterns and their aborts occur often.

// File: rtl/sw_reg_entry_pkg.sv
package sw_reg_entry_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD1  = 2'd1,
    SQ_RD2  = 2'd2,
    SQ_SEL  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sw_seq_fsm.sv
module sw_seq_fsm
  import sw_reg_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic we_i,
  input  logic top_hit_i,
  input  logic sel_ok_i,
  output logic armed_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (vld_i) begin
      unique case (state_q)
        SQ_IDLE: state_d = (top_hit_i && !we_i) ? SQ_RD1 : SQ_IDLE;
        SQ_RD1:  state_d = (top_hit_i && !we_i) ? SQ_RD2 : SQ_IDLE;
        SQ_RD2:  state_d = (top_hit_i && we_i && sel_ok_i) ? SQ_SEL : SQ_IDLE;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == SQ_SEL);
endmodule

// File: rtl/sw_cfg_reg.sv
module sw_cfg_reg #(
  parameter int          REG_W     = 20,
  parameter int          BUS_W     = 16,
  parameter int          DPD_BIT   = 4,
  parameter logic [19:0] CFG_RESET = 20'hA0003
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [REG_W-1:0] cfg_o
);
  localparam int HI_W = REG_W - BUS_W;
  localparam logic [BUS_W-1:0] DPD_MASK = BUS_W'(1) << DPD_BIT;

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET[REG_W-1:0];
    else if (wr_en_i) cfg_q <= {cfg_q[REG_W-1 -: HI_W], wdata_i & ~DPD_MASK};
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sw_reg_entry.sv
module sw_reg_entry #(
  parameter int          ADDR_W    = 20,
  parameter int          BUS_W     = 16,
  parameter int          REG_W     = 20,
  parameter int          DPD_BIT   = 4,
  parameter logic [15:0] SEL_CODE  = 16'h0000,
  parameter logic [19:0] CFG_RESET = 20'hA0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_vld_i,
  input  logic              cyc_we_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic [BUS_W-1:0]  cyc_wdata_i,
  input  logic [BUS_W-1:0]  array_rdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              reg_acc_o,
  output logic [REG_W-1:0]  cfg_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic top_hit, sel_ok, armed;

  assign top_hit = (cyc_addr_i == TOP_ADDR);
  assign sel_ok  = (cyc_wdata_i == SEL_CODE[BUS_W-1:0]);

  sw_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (cyc_vld_i),
    .we_i      (cyc_we_i),
    .top_hit_i (top_hit),
    .sel_ok_i  (sel_ok),
    .armed_o   (armed)
  );

  // fourth access of a valid pattern goes to the register, not the array
  assign reg_acc_o = cyc_vld_i && armed && top_hit;

  sw_cfg_reg #(
    .REG_W     (REG_W),
    .BUS_W     (BUS_W),
    .DPD_BIT   (DPD_BIT),
    .CFG_RESET (CFG_RESET)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (reg_acc_o && cyc_we_i),
    .wdata_i (cyc_wdata_i),
    .cfg_o   (cfg_o)
  );

  assign rdata_o = (reg_acc_o && !cyc_we_i) ? cfg_o[BUS_W-1:0] : array_rdata_i;
endmodule

// File: rtl/sw_reg_entry_chk.sv
module sw_reg_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_vld_i,
  input logic        cyc_we_i,
  input logic [19:0] cyc_addr_i,
  input logic [15:0] cyc_wdata_i,
  input logic [15:0] array_rdata_i,
  input logic [15:0] rdata_o,
  input logic        reg_acc_o,
  input logic [19:0] cfg_o
);
  a_r2_top_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_acc_o |-> (cyc_vld_i && cyc_addr_i == 20'hFFFFF));
  a_r10_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_acc_o |=> !reg_acc_o);
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_acc_o && cyc_we_i) |=> cfg_o[15:0] == ($past(cyc_wdata_i) & 16'hFFEF));
  a_r4_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_acc_o && cyc_we_i) |=> cfg_o[19:16] == $past(cfg_o[19:16]));
  a_r5_no_dpd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_acc_o && cyc_we_i) |=> !cfg_o[4]);
  a_r12_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_acc_o && cyc_we_i) |=> $stable(cfg_o));
  a_r6_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_acc_o && !cyc_we_i) |-> rdata_o == cfg_o[15:0]);
  a_r7_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_acc_o |-> rdata_o == array_rdata_i);
endmodule

bind sw_reg_entry sw_reg_entry_chk u_chk (.*);

// File: tb/sim_sw_reg_entry.sv
module sim_sw_reg_entry;
  logic        clk = 0, rst_ni = 0;
  logic        vld = 0, we = 0;
  logic [19:0] addr = '0;
  logic [15:0] wd = '0, ad = '0;
  logic [15:0] rdata;
  logic        racc;
  logic [19:0] cfg;

  int n_chk = 0, n_err = 0;
  int mst = 0;
  logic [19:0] mcfg = 20'hA0003;
  localparam logic [19:0] TOP = 20'hFFFFF;

  always #5 clk = ~clk;

  sw_reg_entry u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_vld_i(vld), .cyc_we_i(we),
    .cyc_addr_i(addr), .cyc_wdata_i(wd), .array_rdata_i(ad),
    .rdata_o(rdata), .reg_acc_o(racc), .cfg_o(cfg)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_st(int s, logic v, logic w, logic [19:0] a, logic [15:0] d);
    if (!v) return s;
    case (s)
      0: return (a == TOP && !w) ? 1 : 0;
      1: return (a == TOP && !w) ? 2 : 0;
      2: return (a == TOP && w && d == 16'h0) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(string tag, logic v, logic w, logic [19:0] a, logic [15:0] d);
    logic ea;
    @(negedge clk);
    vld = v; we = w; addr = a; wd = d; ad = 16'($urandom);
    #2;
    ea = v && mst == 3 && a == TOP;
    chk({tag, " acc"}, 32'(racc), 32'(ea));
    chk({tag, " rdata"}, 32'(rdata), 32'((ea && !w) ? mcfg[15:0] : ad));
    @(posedge clk);
    if (ea && w) mcfg[15:0] = d & 16'hFFEF;
    mst = next_st(mst, v, w, a, d);
    #1;
    chk({tag, " cfg"}, 32'(cfg), 32'(mcfg));
  endtask

  task automatic entry(string tag);
    cyc(tag, 1, 0, TOP, 16'h1234);
    cyc(tag, 1, 0, TOP, 16'h1234);
    cyc(tag, 1, 1, TOP, 16'h0000);
  endtask

  initial begin
    #20000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset cfg", 32'(cfg), 32'h000A0003);
    chk("R1 reset acc", 32'(racc), 32'd0);
    @(negedge clk); rst_ni = 1;

    entry("R2");
    cyc("R3 R4 R5 write", 1, 1, TOP, 16'hFFFF);
    entry("R6");
    cyc("R6 read", 1, 0, TOP, 16'h0);
    cyc("R10 after fourth", 1, 0, TOP, 16'h0);
    entry("R8 addr");
    cyc("R8 addr abort", 1, 1, 20'hFFFFE, 16'h5555);
    cyc("R8 addr abort", 1, 1, TOP, 16'h5555);
    cyc("R8 type", 1, 0, TOP, 0); cyc("R8 type", 1, 1, TOP, 0);
    cyc("R8 type abort", 1, 0, TOP, 0);
    cyc("R9 sel", 1, 0, TOP, 0); cyc("R9 sel", 1, 0, TOP, 0);
    cyc("R9 sel nonzero", 1, 1, TOP, 16'h0001);
    cyc("R9 abort", 1, 1, TOP, 16'h00AA);
    cyc("R10 third read", 1, 0, TOP, 0); cyc("R10 third read", 1, 0, TOP, 0);
    cyc("R10 third read", 1, 0, TOP, 0);
    cyc("R10 third read", 1, 1, TOP, 0);
    cyc("R10 third read", 1, 1, TOP, 16'h7777);
    cyc("R11 gap", 1, 0, TOP, 0); cyc("R11 gap", 0, 1, 20'h0, 0);
    cyc("R11 gap", 1, 0, TOP, 0); cyc("R11 gap", 0, 0, 20'h1, 0);
    cyc("R11 gap", 1, 1, TOP, 0); cyc("R11 gap", 0, 1, 20'h3, 16'h9);
    cyc("R11 write", 1, 1, TOP, 16'h8421);
    cyc("R12 idle", 1, 1, TOP, 16'hBEEF);

    for (int i = 0; i < 3000; i++) begin
      logic [19:0] ra;
      logic [15:0] rd;
      ra = ($urandom_range(0, 9) < 8) ? TOP : 20'($urandom);
      rd = ($urandom_range(0, 1) == 0) ? 16'h0 : 16'($urandom);
      cyc("R12 random", ($urandom_range(0, 7) != 0), 1'($urandom), ra, rd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule